// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block turns four asynchronous external interrupt pins into four synchronous interrupt requests for a processor. Each pin is brought into the clock domain by a two-flop synchronizer. Each channel then checks the pin against its own trigger setting. A channel can respond to a level, either high or low. It can also respond to an edge: rising, falling, or both.

Edge events are held in a per-channel latch until software acknowledges them. Software acknowledges an event by writing a 1 to that channel's clear bit. Each request output passes through the channel's mask bit and a final register before it leaves the block.

All settings sit in one 32-bit control register with a single write strobe and a continuous read-back. Every write replaces the whole register, so software has to repeat the current configuration when it writes clear bits. The clear bits act only during the write cycle and are never stored.

Top module: `xtrig_unit`

## Requirements
- R1: After a synchronous reset, all request outputs are 0. The register reads 0x0000_00F0: mask=0, level-sense=1 and sense=0 on all channels (level, active-low), and both-edge=0.
- R2: Register layout, with channel n at offset n inside each field: mask in bits [3:0], level-sense in [7:4], sense in [11:8], both-edge in [15:12] and clear in [19:16]. A write stores bits [15:0], which read back unchanged. Bits [31:16] always read 0, including the clear bits just written.
- R3: In level mode (level-sense=1) with sense=1 and mask=1, the request is 1 while the pin is high and 0 while it is low.
- R4: In level mode with sense=0 and mask=1, the request is 1 while the pin is low and 0 while it is high.
- R5: In edge mode (level-sense=0) with both-edge=0 and sense=1, a rising transition sets the request and a falling one does not.
- R6: In edge mode with both-edge=0 and sense=0, a falling transition sets the request and a rising one does not.
- R7: In edge mode with both-edge=1, both rising and falling transitions set the request, whatever the sense bit holds.
- R8: A latched edge event keeps the request at 1 after the pin returns to its idle level, until the event is cleared.
- R9: Writing 1 to a channel's clear bit removes its latched event, so the request drops to 0. If a new qualifying edge is detected in the same cycle as the clear, the latch stays set.
- R10: A channel whose mask bit is 0 drives its request output to 0, whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | 4 | Asynchronous external interrupt pins |
| cfg_wr_i | input | 1 | Write strobe for the control register |
| cfg_wdata_i | input | 32 | Write data for the control register |
| cfg_rdata_o | output | 32 | Current control register contents |
| irq_req_o | output | 4 | Registered, masked interrupt requests |

## Verification
The acknowledge write and the detection of a fresh edge can land on the same clock edge. On that edge the write tries to clear the latch while the detector tries to set it.

The bench provokes this by moving a pin and then counting the two synchronizer flops. It issues the clear write exactly in the cycle where the synchronized value first differs from its previous sample. It then expects the request to stay at 1.

A separate clear with no edge present is expected to drop the request to 0. This shows that the first result came from the overlap and not from an ignored clear.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  typedef enum logic [2:0] {
    TRIG_LEVEL_LOW,
    TRIG_LEVEL_HIGH,
    TRIG_EDGE_RISE,
    TRIG_EDGE_FALL,
    TRIG_EDGE_ANY
  } trig_mode_e;

  // Map the three per-channel control bits to one trigger mode.
  function automatic trig_mode_e decode_mode(input logic lvl, input logic sns, input logic both);
    if (lvl)       return sns ? TRIG_LEVEL_HIGH : TRIG_LEVEL_LOW;
    else if (both) return TRIG_EDGE_ANY;
    else           return sns ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
  endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xtrig_cfg.sv
module xtrig_cfg #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] sns_o,
  output logic [NUM_CH-1:0] both_o,
  output logic [NUM_CH-1:0] clr_o
);
  localparam int unsigned STORED_W = 4 * NUM_CH;
  localparam int unsigned USED_W   = 5 * NUM_CH;
  localparam int unsigned PAD_W    = DATA_W - STORED_W;

  logic [NUM_CH-1:0] mask_q, lvl_q, sns_q, both_q;
  logic              unused_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      lvl_q  <= '1;
      sns_q  <= '0;
      both_q <= '0;
    end else if (wr_i) begin
      mask_q <= wdata_i[0*NUM_CH +: NUM_CH];
      lvl_q  <= wdata_i[1*NUM_CH +: NUM_CH];
      sns_q  <= wdata_i[2*NUM_CH +: NUM_CH];
      both_q <= wdata_i[3*NUM_CH +: NUM_CH];
    end
  end

  // Clear bits act during the write cycle only; they are never stored.
  assign clr_o     = wr_i ? wdata_i[4*NUM_CH +: NUM_CH] : '0;
  assign unused_hi = ^wdata_i[DATA_W-1:USED_W];

  assign rdata_o = {{PAD_W{1'b0}}, both_q, sns_q, lvl_q, mask_q};
  assign mask_o  = mask_q;
  assign lvl_o   = lvl_q;
  assign sns_o   = sns_q;
  assign both_o  = both_q;
endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
  import xtrig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_now_i,
  input  logic pin_prev_i,
  input  logic lvl_i,
  input  logic sns_i,
  input  logic both_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic req_o
);
  trig_mode_e mode;
  logic       hit;
  logic       level_ok;
  logic       held_q;

  always_comb begin
    mode     = decode_mode(lvl_i, sns_i, both_i);
    hit      = 1'b0;
    level_ok = 1'b0;
    unique case (mode)
      TRIG_LEVEL_LOW:  level_ok = !pin_now_i;
      TRIG_LEVEL_HIGH: level_ok = pin_now_i;
      TRIG_EDGE_RISE:  hit = pin_now_i && !pin_prev_i;
      TRIG_EDGE_FALL:  hit = !pin_now_i && pin_prev_i;
      TRIG_EDGE_ANY:   hit = pin_now_i ^ pin_prev_i;
      default:         hit = 1'b0;
    endcase
  end

  // Edge latch: a new hit wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || lvl_i) held_q <= 1'b0;
    else              held_q <= (held_q && !clr_i) || hit;
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= mask_i && (lvl_i ? level_ok : held_q);
  end
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] irq_pin_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [NUM_CH-1:0] irq_req_o
);
  logic [NUM_CH-1:0] pin_sync, pin_prev;
  logic [NUM_CH-1:0] mask, lvl, sns, both, clr;

  xtrig_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(irq_pin_i), .q_o(pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= '0;
    else     pin_prev <= pin_sync;
  end

  xtrig_cfg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .mask_o(mask), .lvl_o(lvl), .sns_o(sns),
    .both_o(both), .clr_o(clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xtrig_detect u_det (
      .clk(clk), .rst(rst),
      .pin_now_i(pin_sync[c]), .pin_prev_i(pin_prev[c]),
      .lvl_i(lvl[c]), .sns_i(sns[c]), .both_i(both[c]),
      .mask_i(mask[c]), .clr_i(clr[c]), .req_o(irq_req_o[c])
    );
  end
endmodule

// File: rtl/xtrig_checker.sv
module xtrig_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic [NUM_CH-1:0] irq_req_o
);
  localparam int unsigned STORED_W = 4 * NUM_CH;
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'({NUM_CH{1'b1}}) << NUM_CH;

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after reset shows idle requests and the default configuration
  always @(posedge clk) begin
    if (rst_q) assert_reset_default_R1: assert (irq_req_o == '0 && cfg_rdata_o == RESET_VAL);
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_i |=> (cfg_rdata_o[STORED_W-1:0] == $past(cfg_wdata_i[STORED_W-1:0]))
                 && (cfg_rdata_o[DATA_W-1:STORED_W] == '0));

  assert_mask_gate_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_req_o & ~$past(cfg_rdata_o[NUM_CH-1:0])) == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (irq_req_o[c] && !cfg_wr_i && !$past(cfg_wr_i) && !cfg_rdata_o[NUM_CH + c])
        |=> irq_req_o[c]);
  end
endmodule

bind xtrig_unit xtrig_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o), .irq_req_o(irq_req_o)
);

// File: tb/xtrig_unit_bench.sv
module xtrig_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pins = 4'hF;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_reg;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5ns clk = ~clk;

  xtrig_unit u_xtrig_unit (
    .clk(clk), .rst(rst), .irq_pin_i(pins), .cfg_wr_i(wr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_req_o(req)
  );

  // Monitor: compares each queued expectation against the ports at a falling edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_reg ? rdata : {28'b0, req};
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] mk(logic [3:0] m, logic [3:0] l, logic [3:0] s,
                                     logic [3:0] b, logic [3:0] c);
    return {12'b0, c, b, s, l, m};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit is_reg, logic [31:0] exp, string tag);
    item_t it;
    it.is_reg = is_reg; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg_write(logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_pins(logic [3:0] p);
    @(negedge clk);
    pins = p;
    tick(5);
  endtask

  logic [31:0] edge_cfg;

  initial begin
    tick(3);
    rst = 1'b0;
    push(1'b0, 32'h0, "R1 requests after reset");
    push(1'b1, 32'h0000_00F0, "R1 register after reset");

    cfg_write(mk(4'hF, 4'hF, 4'hF, 4'h0, 4'h0));
    push(1'b1, 32'h0000_0FFF, "R2 readback");
    cfg_write(32'hFFF0_0000 | mk(4'hF, 4'hF, 4'hF, 4'h5, 4'hF));
    push(1'b1, 32'h0000_5FFF, "R2 clear and upper bits read 0");
    cfg_write(mk(4'hF, 4'hF, 4'hF, 4'h0, 4'h0));

    set_pins(4'b0101);
    push(1'b0, 32'h5, "R3 level high 0101");
    set_pins(4'b1010);
    push(1'b0, 32'hA, "R3 level high 1010");

    cfg_write(mk(4'hF, 4'hF, 4'h0, 4'h0, 4'h0));
    tick(4);
    push(1'b0, 32'h5, "R4 level low pins 1010");

    cfg_write(mk(4'b0011, 4'hF, 4'h0, 4'h0, 4'h0));
    set_pins(4'b0000);
    push(1'b0, 32'h3, "R10 mask gates level requests");

    // Edge mode: ch0 rise, ch1 fall, ch2 both (sense 1), ch3 both (sense 0).
    edge_cfg = mk(4'hF, 4'h0, 4'b0101, 4'b1100, 4'h0);
    cfg_write(edge_cfg);
    tick(4);
    push(1'b0, 32'h0, "R5 no event before edges");
    set_pins(4'b1111);
    push(1'b0, 32'hD, "R5 R7 rising edges");
    set_pins(4'b0000);
    push(1'b0, 32'hF, "R8 latched events held, R6 R7 falling");
    cfg_write(edge_cfg | mk(4'h0, 4'h0, 4'h0, 4'h0, 4'hF));
    tick(3);
    push(1'b0, 32'h0, "R9 clear all");
    set_pins(4'b1111);
    cfg_write(edge_cfg | mk(4'h0, 4'h0, 4'h0, 4'h0, 4'hF));
    tick(3);
    push(1'b0, 32'h0, "R9 clear after rise");
    set_pins(4'b0000);
    push(1'b0, 32'hE, "R6 falling only on ch1, ch0 quiet");
    cfg_write(edge_cfg | mk(4'h0, 4'h0, 4'h0, 4'h0, 4'hF));
    tick(3);

    // Same-cycle clear and new edge on ch0.
    set_pins(4'b0001);
    push(1'b0, 32'h1, "R5 ch0 rise");
    set_pins(4'b0000);
    push(1'b0, 32'h1, "R8 ch0 held after return to idle");
    @(negedge clk);
    pins = 4'b0001;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr = 1'b1; wdata = edge_cfg | mk(4'h0, 4'h0, 4'h0, 4'h0, 4'h1);
    @(negedge clk);
    wr = 1'b0;
    tick(3);
    push(1'b0, 32'h1, "R9 edge in clear cycle re-sets latch");
    cfg_write(edge_cfg | mk(4'h0, 4'h0, 4'h0, 4'h0, 4'h1));
    tick(3);
    push(1'b0, 32'h0, "R9 plain clear drops request");

    cfg_write(mk(4'h0, 4'h0, 4'h0, 4'hF, 4'h0));
    set_pins(4'b1110);
    push(1'b0, 32'h0, "R10 masked edges give no request");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule